// File: doc/BRIEF.md
# USB host port status/control register

This block holds the status and control state of one downstream port of a high-speed USB host controller. Software sees it as a single register on a plain write-strobe/readback bus. Behind that register sits the port's life cycle: a bus reset that software starts and asks to end, automatic enabling when a high-speed device answers the reset, suspend that waits for the current transaction to drain, resume signalling that either software or the line can start, and overcurrent reporting.

Several bits do not behave as plain storage. Suspend cannot be cleared by software. Port reset and force-resume keep reading 1 after software clears them, until the line logic reports through a handshake input that the operation has finished. Overcurrent change is cleared by writing 1. Line signalling and real-time timers are outside the block. The line logic answers through handshake inputs, and a parameterised cycle bound raises a sticky timeout flag if an answer arrives late. Every write carries the full register image, so software normally writes back a modified readback value.

Register field positions (bit: meaning): 0 port enable, 1 suspend, 2 force-resume, 3 port reset, 4 overcurrent active, 5 overcurrent change (write 1 to clear), 6 handshake timeout (write 1 to clear). All higher bits read 0.

Top module: `usb_port_ctrl`

## Requirements
- R1: After reset every register bit reads 0 and port_chg_o, drive_resume_o and drive_reset_o are 0.
- R2: A write with bit 3 = 1 while bit 3 reads 0 starts a bus reset. From the next cycle bit 3 reads 1, drive_reset_o is 1, and bits 0, 1 and 2 read 0 whatever the write held.
- R3: A write with bit 3 = 0 during a reset only requests the end of the reset. Bit 3 keeps reading 1 until rst_done_i is seen high in a later cycle.
- R4: The cycle after reset completion is sampled, bit 3 and drive_reset_o read 0 and bit 0 takes the value of hs_dev_i in that completion cycle.
- R5: Writing 0 to bit 1 never clears suspend. Suspend is cleared when software clears force-resume, starts a port reset, or disables the port.
- R6: Writing 1 to bit 1 while the port is enabled and not suspended sets suspend in the next cycle if xact_busy_i is 0. Otherwise bit 1 reads 0 until the first cycle in which xact_busy_i is 0, and is then set in the following cycle.
- R7: While suspended with bit 2 at 0, a cycle with jk_seen_i high sets bit 2 and produces a one-cycle port_chg_o pulse in the next cycle. Setting bit 2 by a software write produces no pulse.
- R8: drive_resume_o is 1 while force-resume is set and software has not yet cleared it. After software writes 0 to bit 2, drive_resume_o drops, suspend drops, and bit 2 reads 1 until resume_done_i is seen high.
- R9: Bit 4 reads the value oc_i had one cycle earlier. Bit 5 is set whenever bit 4 changes value and is cleared by a write with bit 5 = 1. A change has priority over the clear.
- R10: While halted_i is 1, a pending end of reset is not completed, even if rst_done_i is high.
- R11: If the reset-end or resume-end handshake has not arrived after TMO_CYC waiting cycles, bit 6 sets and stays set until a write with bit 6 = 1. Cycles with halted_i high do not count toward the reset wait.
- R12: Writing 1 to bit 1 while bit 0 reads 0 is ignored and suspend stays 0.
- R13: Writing 0 to bit 0 disables the port and clears suspend. Writing 1 to bit 0 has no effect, so only reset completion enables the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | DATA_W | Full register image to write |
| rd_data_o | output | DATA_W | Register readback |
| rst_done_i | input | 1 | Line logic has finished the bus reset |
| hs_dev_i | input | 1 | A high-speed device was detected during reset |
| jk_seen_i | input | 1 | J-to-K transition observed on the line |
| xact_busy_i | input | 1 | A transaction is in progress on the port |
| resume_done_i | input | 1 | Line logic has reached high-speed idle after resume |
| oc_i | input | 1 | Overcurrent condition present |
| halted_i | input | 1 | Host controller is halted |
| port_chg_o | output | 1 | One-cycle port change pulse to the global status register |
| drive_resume_o | output | 1 | Drive resume signalling on the line |
| drive_reset_o | output | 1 | Drive bus reset signalling on the line |

## Verification
The properties assume that port_chg_o can follow only a line-detected J-to-K event, and that a handshake bit read as 1 stays 1 until its done input arrives, except that a new port reset clears force-resume. They also assume that oc_i is a clean level sampled every cycle. The stimulus raises handshake and line inputs only in the states where they mean something. It changes all inputs away from the active edge and builds each write image from the expected readback, so that unrelated bits, port enable in particular, are written back unchanged. No write coincides with a hardware event on the same bit.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  localparam int unsigned F_EN   = 0;
  localparam int unsigned F_SUSP = 1;
  localparam int unsigned F_FPR  = 2;
  localparam int unsigned F_RST  = 3;
  localparam int unsigned F_OCA  = 4;
  localparam int unsigned F_OCC  = 5;
  localparam int unsigned F_TMO  = 6;
  localparam int unsigned NUM_FIELDS = 7;

  typedef enum logic [1:0] {
    PS_DISABLED  = 2'd0,
    PS_ENABLED   = 2'd1,
    PS_SUSPENDED = 2'd2
  } port_state_e;

  function automatic port_state_e port_state(input logic en, input logic susp);
    if (!en)       return PS_DISABLED;
    else if (susp) return PS_SUSPENDED;
    else           return PS_ENABLED;
  endfunction
endpackage

// File: rtl/usb_port_hs_timer.sv
module usb_port_hs_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic done_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!wait_i)                   cnt_q <= '0;
    else if (cnt_q != CNT_W'(LIMIT))    cnt_q <= cnt_q + 1'b1;
  end

  // fires once, in the LIMIT-th waiting cycle without done
  assign expire_o = wait_i && !done_i && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/usb_port_rst_ctl.sv
module usb_port_rst_ctl #(
  parameter int unsigned TMO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_set_i,
  input  logic rst_clr_i,
  input  logic sw_dis_i,
  input  logic rst_done_i,
  input  logic hs_dev_i,
  input  logic halted_i,
  output logic reset_o,
  output logic enable_o,
  output logic tmo_o
);
  logic rst_q, end_q, en_q;
  logic can_finish;

  assign can_finish = end_q && !halted_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      end_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (rst_set_i) begin
      rst_q <= 1'b1;
      end_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (can_finish && rst_done_i) begin
      rst_q <= 1'b0;
      end_q <= 1'b0;
      en_q  <= hs_dev_i;
    end else begin
      if (rst_clr_i) end_q <= 1'b1;
      if (sw_dis_i)  en_q  <= 1'b0;
    end
  end

  usb_port_hs_timer #(.LIMIT(TMO_CYC)) i_rst_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wait_i   (can_finish),
    .done_i   (rst_done_i),
    .expire_o (tmo_o)
  );

  assign reset_o  = rst_q;
  assign enable_o = en_q;
endmodule

// File: rtl/usb_port_susp_ctl.sv
module usb_port_susp_ctl
  import usb_port_pkg::*;
#(
  parameter int unsigned TMO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic kill_i,
  input  logic susp_set_i,
  input  logic fpr_set_i,
  input  logic fpr_wr0_i,
  input  logic xact_busy_i,
  input  logic jk_seen_i,
  input  logic resume_done_i,
  output logic susp_o,
  output logic fpr_o,
  output logic drive_resume_o,
  output logic chg_o,
  output logic tmo_o
);
  logic susp_q, pend_q, fpr_q, end_q, chg_q;
  port_state_e st;

  assign st = port_state(en_i, susp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
      pend_q <= 1'b0;
      fpr_q  <= 1'b0;
      end_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (kill_i) begin
        susp_q <= 1'b0;
        pend_q <= 1'b0;
        fpr_q  <= 1'b0;
        end_q  <= 1'b0;
      end else begin
        // suspend entry waits for the bus to drain
        if (susp_set_i && st == PS_ENABLED && !pend_q) begin
          if (xact_busy_i) pend_q <= 1'b1;
          else             susp_q <= 1'b1;
        end else if (pend_q && !xact_busy_i) begin
          pend_q <= 1'b0;
          susp_q <= 1'b1;
        end
        if (end_q && resume_done_i) begin
          fpr_q <= 1'b0;
          end_q <= 1'b0;
        end else if (fpr_q && !end_q && fpr_wr0_i) begin
          end_q  <= 1'b1;
          susp_q <= 1'b0;
        end else if (st == PS_SUSPENDED && !fpr_q) begin
          if (fpr_set_i) begin
            fpr_q <= 1'b1;
          end else if (jk_seen_i) begin
            fpr_q <= 1'b1;
            chg_q <= 1'b1;
          end
        end
      end
    end
  end

  usb_port_hs_timer #(.LIMIT(TMO_CYC)) i_res_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wait_i   (end_q),
    .done_i   (resume_done_i),
    .expire_o (tmo_o)
  );

  assign susp_o         = susp_q;
  assign fpr_o          = fpr_q;
  assign drive_resume_o = fpr_q && !end_q;
  assign chg_o          = chg_q;
endmodule

// File: rtl/usb_port_oc_ctl.sv
module usb_port_oc_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic chg_w1c_i,
  output logic oca_o,
  output logic occ_o
);
  logic oca_q, occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oca_q <= 1'b0;
      occ_q <= 1'b0;
    end else begin
      oca_q <= oc_i;
      if (oc_i != oca_q) occ_q <= 1'b1;
      else if (chg_w1c_i) occ_q <= 1'b0;
    end
  end

  assign oca_o = oca_q;
  assign occ_o = occ_q;
endmodule

// File: rtl/usb_port_ctrl.sv
module usb_port_ctrl
  import usb_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TMO_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rst_done_i,
  input  logic              hs_dev_i,
  input  logic              jk_seen_i,
  input  logic              xact_busy_i,
  input  logic              resume_done_i,
  input  logic              oc_i,
  input  logic              halted_i,
  output logic              port_chg_o,
  output logic              drive_resume_o,
  output logic              drive_reset_o
);
  logic reset_w, enable_w, susp_w, fpr_w, oca_w, occ_w;
  logic rst_tmo_w, res_tmo_w, tmo_q;
  logic rst_set, rst_clr, sw_dis, kill;

  assign rst_set = wr_en_i &&  wr_data_i[F_RST] && !reset_w;
  assign rst_clr = wr_en_i && !wr_data_i[F_RST] &&  reset_w;
  assign sw_dis  = wr_en_i && !wr_data_i[F_EN];
  assign kill    = rst_set || sw_dis;

  usb_port_rst_ctl #(.TMO_CYC(TMO_CYC)) i_rst_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_set_i  (rst_set),
    .rst_clr_i  (rst_clr),
    .sw_dis_i   (sw_dis),
    .rst_done_i (rst_done_i),
    .hs_dev_i   (hs_dev_i),
    .halted_i   (halted_i),
    .reset_o    (reset_w),
    .enable_o   (enable_w),
    .tmo_o      (rst_tmo_w)
  );

  usb_port_susp_ctl #(.TMO_CYC(TMO_CYC)) i_susp_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (enable_w),
    .kill_i         (kill),
    .susp_set_i     (wr_en_i && wr_data_i[F_SUSP]),
    .fpr_set_i      (wr_en_i && wr_data_i[F_FPR]),
    .fpr_wr0_i      (wr_en_i && !wr_data_i[F_FPR]),
    .xact_busy_i    (xact_busy_i),
    .jk_seen_i      (jk_seen_i),
    .resume_done_i  (resume_done_i),
    .susp_o         (susp_w),
    .fpr_o          (fpr_w),
    .drive_resume_o (drive_resume_o),
    .chg_o          (port_chg_o),
    .tmo_o          (res_tmo_w)
  );

  usb_port_oc_ctl i_oc_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oc_i      (oc_i),
    .chg_w1c_i (wr_en_i && wr_data_i[F_OCC]),
    .oca_o     (oca_w),
    .occ_o     (occ_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tmo_q <= 1'b0;
    else if (rst_tmo_w || res_tmo_w)      tmo_q <= 1'b1;
    else if (wr_en_i && wr_data_i[F_TMO]) tmo_q <= 1'b0;
  end

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[F_EN]   = enable_w;
    rd_data_o[F_SUSP] = susp_w;
    rd_data_o[F_FPR]  = fpr_w;
    rd_data_o[F_RST]  = reset_w;
    rd_data_o[F_OCA]  = oca_w;
    rd_data_o[F_OCC]  = occ_w;
    rd_data_o[F_TMO]  = tmo_q;
  end

  assign drive_reset_o = reset_w;

  generate
    if (DATA_W > NUM_FIELDS) begin : g_spare
      logic unused_wr_bits;
      assign unused_wr_bits = ^wr_data_i[DATA_W-1:NUM_FIELDS];
    end
  endgenerate
endmodule

// File: rtl/usb_port_ctrl_chk.sv
module usb_port_ctrl_chk
  import usb_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rst_done_i,
  input logic              hs_dev_i,
  input logic              jk_seen_i,
  input logic              resume_done_i,
  input logic              oc_i,
  input logic              halted_i,
  input logic              port_chg_o,
  input logic              drive_resume_o
);
  logic new_reset;
  assign new_reset = wr_en_i && wr_data_i[F_RST] && !rd_data_o[F_RST];

  p_rst_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[F_RST] && !rst_done_i |=> rd_data_o[F_RST]);

  p_rst_done_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[F_RST]) |-> rd_data_o[F_EN] == $past(hs_dev_i));

  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[F_RST] && halted_i |=> rd_data_o[F_RST]);

  p_chg_from_jk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_chg_o |-> $past(jk_seen_i) && rd_data_o[F_FPR]);

  p_fpr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[F_FPR] && !resume_done_i && !new_reset |=> rd_data_o[F_FPR]);

  p_drv_res_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_resume_o |-> rd_data_o[F_FPR]);

  p_susp_en_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[F_SUSP] |-> rd_data_o[F_EN]);

  p_oca_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |=> rd_data_o[F_OCA]);

  p_oca_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_i |=> !rd_data_o[F_OCA]);

  p_occ_on_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_i != rd_data_o[F_OCA]) |=> rd_data_o[F_OCC]);
endmodule

bind usb_port_ctrl usb_port_ctrl_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_usb_port_ctrl.sv
module test_usb_port_ctrl;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned TMO_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic rst_done = 1'b0, hs_dev = 1'b0, jk_seen = 1'b0, xact_busy = 1'b0;
  logic resume_done = 1'b0, oc = 1'b0, halted = 1'b0;
  logic port_chg, drive_resume, drive_reset;

  always #4 clk = ~clk;

  usb_port_ctrl #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) i_usb_port_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .rd_data_o (rd_data), .rst_done_i (rst_done), .hs_dev_i (hs_dev),
    .jk_seen_i (jk_seen), .xact_busy_i (xact_busy), .resume_done_i (resume_done),
    .oc_i (oc), .halted_i (halted), .port_chg_o (port_chg),
    .drive_resume_o (drive_resume), .drive_reset_o (drive_reset)
  );

  typedef struct {
    string       tag;
    logic [10:0] mask;
    logic [10:0] exp;
  } item_t;

  item_t sb_q[$];
  int n_run = 0;
  int n_fail = 0;
  logic [10:0] obs;
  assign obs = {drive_reset, drive_resume, port_chg, rd_data};

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h (mask %h)", it.tag, obs, it.exp, it.mask);
      end
    end
  end

  task automatic exp_rd(input string tag, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.mask = 11'h0FF; it.exp = {3'b000, v};
    sb_q.push_back(it);
  endtask

  task automatic exp_all(input string tag, input logic [7:0] v,
                         input logic chg, input logic dres, input logic drst);
    item_t it;
    it.tag = tag; it.mask = 11'h7FF; it.exp = {drst, dres, chg, v};
    sb_q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_rst_done();
    @(negedge clk); rst_done = 1'b1;
    @(negedge clk); rst_done = 1'b0;
  endtask

  task automatic pulse_res_done();
    @(negedge clk); resume_done = 1'b1;
    @(negedge clk); resume_done = 1'b0;
  endtask

  logic done_flag = 1'b0;

  initial begin
    #(8 * 20000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    exp_all("R1 reset state", 8'h00, 1'b0, 1'b0, 1'b0);

    // port reset with high-speed device
    hs_dev = 1'b1;
    wr(8'h08);
    exp_all("R2 reset started", 8'h08, 1'b0, 1'b0, 1'b1);
    wr(8'h00);
    exp_rd("R3 reset reads 1 after sw clear", 8'h08);
    tick(4);
    exp_all("R3 reset still held", 8'h08, 1'b0, 1'b0, 1'b1);
    pulse_rst_done();
    exp_all("R4 hs reset completes enabled", 8'h01, 1'b0, 1'b0, 1'b0);

    // suspend delayed by transaction
    xact_busy = 1'b1;
    wr(8'h03);
    exp_rd("R6 suspend pending while busy", 8'h01);
    tick(3);
    exp_rd("R6 suspend still pending", 8'h01);
    xact_busy = 1'b0;
    tick(1);
    exp_rd("R6 suspend after idle", 8'h03);

    wr(8'h01);
    exp_rd("R5 sw write 0 to suspend ignored", 8'h03);

    // line-detected resume
    jk_seen = 1'b1;
    tick(1);
    jk_seen = 1'b0;
    exp_all("R7 jk sets fpr and pulses change", 8'h07, 1'b1, 1'b1, 1'b0);
    tick(1);
    exp_all("R7 change pulse is one cycle", 8'h07, 1'b0, 1'b1, 1'b0);
    wr(8'h03);
    exp_all("R8 fpr lingers, drive stops, suspend drops", 8'h05, 1'b0, 1'b0, 1'b0);
    tick(3);
    exp_rd("R8 fpr held until idle", 8'h05);
    pulse_res_done();
    exp_rd("R8 fpr clears at idle", 8'h01);

    // software-driven resume
    wr(8'h03);
    exp_rd("R6 suspend immediate when idle", 8'h03);
    wr(8'h07);
    exp_all("R7 sw fpr gives no change pulse", 8'h07, 1'b0, 1'b1, 1'b0);
    tick(1);
    exp_all("R7 still no pulse", 8'h07, 1'b0, 1'b1, 1'b0);
    wr(8'h03);
    exp_rd("R8 sw cleared fpr", 8'h05);

    // resume handshake timeout
    tick(8);
    exp_rd("R11 no timeout before limit", 8'h05);
    tick(16);
    exp_rd("R11 resume timeout raised", 8'h45);
    pulse_res_done();
    exp_rd("R11 timeout sticky after done", 8'h41);
    wr(8'h41);
    exp_rd("R11 timeout w1c", 8'h01);

    // reset clears suspend, halted holds reset
    wr(8'h03);
    exp_rd("R6 suspend again", 8'h03);
    wr(8'h0B);
    exp_all("R5 reset clears suspend", 8'h08, 1'b0, 1'b0, 1'b1);
    halted = 1'b1;
    rst_done = 1'b1;
    wr(8'h00);
    tick(5);
    exp_rd("R10 halted holds reset", 8'h08);
    halted = 1'b0;
    tick(1);
    rst_done = 1'b0;
    exp_rd("R10 reset completes after unhalt", 8'h01);

    // full-speed device: not enabled
    hs_dev = 1'b0;
    wr(8'h09);
    exp_rd("R2 reset forces enable 0", 8'h08);
    rst_done = 1'b1;
    wr(8'h00);
    exp_rd("R3 end requested", 8'h08);
    tick(1);
    rst_done = 1'b0;
    exp_all("R4 non-hs reset leaves disabled", 8'h00, 1'b0, 1'b0, 1'b0);

    wr(8'h02);
    exp_rd("R12 suspend while disabled ignored", 8'h00);
    wr(8'h01);
    exp_rd("R13 sw enable write ignored", 8'h00);

    // reset handshake timeout
    hs_dev = 1'b1;
    wr(8'h08);
    wr(8'h00);
    tick(24);
    exp_rd("R11 reset timeout raised", 8'h48);
    pulse_rst_done();
    exp_rd("R4 enabled after late done", 8'h41);
    wr(8'h41);
    exp_rd("R11 timeout cleared", 8'h01);

    wr(8'h03);
    exp_rd("R6 suspended before disable", 8'h03);
    wr(8'h00);
    exp_rd("R13 disable clears enable and suspend", 8'h00);

    // overcurrent
    oc = 1'b1;
    tick(1);
    exp_rd("R9 oc active and change", 8'h30);
    wr(8'h20);
    exp_rd("R9 change w1c", 8'h10);
    oc = 1'b0;
    tick(1);
    exp_rd("R9 oc removed sets change", 8'h20);
    wr(8'h00);
    exp_rd("R9 write 0 keeps change", 8'h20);
    wr(8'h20);
    exp_rd("R9 change cleared", 8'h00);

    tick(1);
    #3;
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule